// File: doc/BRIEF.md
# Bit Test-and-Branch Unit

This unit evaluates the masked bit instructions of a small processor core once the operand byte has been fetched. It handles three instruction families. Branch-on-clear tests whether every masked bit of the operand is zero. Branch-on-set tests whether every masked bit of the operand is one. Bit-set forms the operand with the masked bits forced to one and returns it for write-back. Effective-address generation and the memory bus stay outside the block. The surrounding pipeline supplies the opcode, the operand byte, the mask, the 8-bit relative displacement, the address of the instruction and its length in bytes.

For each accepted instruction the unit registers a result one clock later. The result holds the branch decision, the address of the next instruction to fetch, the write-back byte and its strobe, and the number of bus cycles the instruction costs in its addressing mode. The direct, extended and indexed forms share the same test logic and differ only in their cycle cost. An opcode that the unit does not recognise produces no result.

Top module: `btb_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all outputs are zero.
- R2: Opcodes 0x4F, 0x1F and 0x0F (branch-on-clear) set the taken flag exactly when operand AND mask is zero.
- R3: Opcodes 0x4E, 0x1E and 0x0E (branch-on-set) set the taken flag exactly when (NOT operand) AND mask is zero.
- R4: The next-PC output is (pc + length + sign-extended displacement) modulo 2^16 when taken, and (pc + length) modulo 2^16 otherwise.
- R5: Opcodes 0x4C, 0x1C and 0x0C (bit-set) give write data equal to operand OR mask, with the write strobe high for that result cycle only, and the taken flag low.
- R6: For branch opcodes the write strobe is low and the write data is zero.
- R7: Branch opcodes cost 4 cycles when the high nibble is 4 (direct), 5 when it is 1 (extended), and the instruction length when it is 0 (indexed). An indexed length below 4 counts as 4 and one above 6 counts as 6.
- R8: Bit-set costs 6 cycles in indexed form with a length of 6 or more, and 4 cycles in every other form.
- R9: A result appears with the valid flag high on the clock edge after the input was accepted. The valid flag and the write strobe are low in any cycle without a new result, and the other outputs keep their last values.
- R10: An opcode outside the nine listed above yields no valid result and no write strobe, and leaves the other outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction fields below are present this cycle |
| in_opcode | input | 8 | Instruction opcode byte |
| in_operand | input | 8 | Fetched memory operand byte |
| in_mask | input | 8 | Mask byte from the instruction |
| in_disp | input | 8 | Signed relative displacement |
| in_pc | input | 16 | Address of the instruction |
| in_len | input | 3 | Instruction length in bytes |
| out_valid | output | 1 | A result is present this cycle |
| out_taken | output | 1 | The branch is taken |
| out_next_pc | output | 16 | Address of the next instruction to fetch |
| out_wr_data | output | 8 | Byte to write back |
| out_wr_en | output | 1 | Write-back strobe |
| out_cycles | output | 3 | Bus cycle cost of the instruction |

## Verification
The bench builds the unit with its default widths: a 16-bit program counter, an 8-bit operand and mask, and an 8-bit displacement. With these widths, wrap-around of the program counter in both directions is reachable, as are the extreme displacements 0x7F and 0x80. Operands and masks that are all ones or all zeros are also reachable, and these decide the branch conditions at their edges. Directed cases cover each addressing mode and each indexed length, and a long random run covers back-to-back, idle and unrecognised-opcode cycles.

// File: rtl/btb_pkg.sv
package btb_pkg;

   localparam int OPC_W = 8;

   typedef enum logic [1:0] {
      K_NONE   = 2'd0,
      K_BR_CLR = 2'd1,
      K_BR_SET = 2'd2,
      K_BSET   = 2'd3
   } kind_t;

   typedef enum logic [1:0] {
      M_DIR = 2'd0,
      M_EXT = 2'd1,
      M_IDX = 2'd2
   } amode_t;

   typedef struct packed {
      kind_t  kind;
      amode_t mode;
   } dec_t;

endpackage

// File: rtl/btb_decode.sv
module btb_decode
   import btb_pkg::*;
(
   input  logic [OPC_W-1:0] opcode,
   output dec_t             dec
);

   logic [3:0] hi_nib;
   logic [3:0] lo_nib;
   logic       mode_ok;

   assign hi_nib = opcode[OPC_W-1 -: 4];
   assign lo_nib = opcode[3:0];

   always_comb begin
      dec.mode = M_DIR;
      mode_ok  = 1'b1;
      unique case (hi_nib)
         4'h4:    dec.mode = M_DIR;
         4'h1:    dec.mode = M_EXT;
         4'h0:    dec.mode = M_IDX;
         default: mode_ok  = 1'b0;
      endcase
   end

   always_comb begin
      dec.kind = K_NONE;
      if (mode_ok) begin
         case (lo_nib)
            4'hF:    dec.kind = K_BR_CLR;
            4'hE:    dec.kind = K_BR_SET;
            4'hC:    dec.kind = K_BSET;
            default: dec.kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/btb_bit_eval.sv
module btb_bit_eval
   import btb_pkg::*;
#(
   parameter int DW = 8
)(
   input  kind_t          kind,
   input  logic [DW-1:0]  operand,
   input  logic [DW-1:0]  mask,
   output logic           cond,
   output logic [DW-1:0]  wdata
);

   logic          want_ones;
   logic [DW-1:0] miss;

   assign want_ones = (kind == K_BR_SET);

   for (genvar b = 0; b < DW; b++) begin : g_bit
      logic seen;
      assign seen     = want_ones ? ~operand[b] : operand[b];
      assign miss[b]  = seen & mask[b];
      assign wdata[b] = operand[b] | mask[b];
   end

   assign cond = ~|miss;

endmodule

// File: rtl/btb_target.sv
module btb_target #(
   parameter int PC_W   = 16,
   parameter int DISP_W = 8,
   parameter int LEN_W  = 3
)(
   input  logic [PC_W-1:0]   pc,
   input  logic [LEN_W-1:0]  len,
   input  logic [DISP_W-1:0] disp,
   output logic [PC_W-1:0]   seq_pc,
   output logic [PC_W-1:0]   jump_pc
);

   localparam int LEN_PAD = PC_W - LEN_W;

   logic [PC_W-1:0] disp_x;

   if (DISP_W == PC_W) begin : g_full_disp
      assign disp_x = disp;
   end else begin : g_sext_disp
      localparam int EXT = PC_W - DISP_W;
      assign disp_x = {{EXT{disp[DISP_W-1]}}, disp};
   end

   assign seq_pc  = pc + {{LEN_PAD{1'b0}}, len};
   assign jump_pc = seq_pc + disp_x;

endmodule

// File: rtl/btb_cycles.sv
module btb_cycles
   import btb_pkg::*;
#(
   parameter int LEN_W = 3,
   parameter int CYC_W = 3
)(
   input  dec_t              dec,
   input  logic [LEN_W-1:0]  len,
   output logic [CYC_W-1:0]  cycles
);

   localparam logic [CYC_W-1:0] C4 = CYC_W'(4);
   localparam logic [CYC_W-1:0] C5 = CYC_W'(5);
   localparam logic [CYC_W-1:0] C6 = CYC_W'(6);
   localparam logic [LEN_W-1:0] L4 = LEN_W'(4);
   localparam logic [LEN_W-1:0] L6 = LEN_W'(6);

   logic [CYC_W-1:0] idx_br;

   always_comb begin
      if (len <= L4)      idx_br = C4;
      else if (len >= L6) idx_br = C6;
      else                idx_br = C5;
   end

   always_comb begin
      cycles = C4;
      if (dec.kind == K_BSET) begin
         if (dec.mode == M_IDX && len >= L6) cycles = C6;
      end else begin
         case (dec.mode)
            M_EXT:   cycles = C5;
            M_IDX:   cycles = idx_br;
            default: cycles = C4;
         endcase
      end
   end

endmodule

// File: rtl/btb_unit.sv
module btb_unit
   import btb_pkg::*;
#(
   parameter int DW     = 8,
   parameter int PC_W   = 16,
   parameter int DISP_W = 8,
   parameter int LEN_W  = 3,
   parameter int CYC_W  = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_opcode,
   input  logic [DW-1:0]     in_operand,
   input  logic [DW-1:0]     in_mask,
   input  logic [DISP_W-1:0] in_disp,
   input  logic [PC_W-1:0]   in_pc,
   input  logic [LEN_W-1:0]  in_len,
   output logic              out_valid,
   output logic              out_taken,
   output logic [PC_W-1:0]   out_next_pc,
   output logic [DW-1:0]     out_wr_data,
   output logic              out_wr_en,
   output logic [CYC_W-1:0]  out_cycles
);

   initial begin
      assert (DW >= 1) else $error("operand width must be positive");
      assert (DISP_W <= PC_W) else $error("displacement wider than PC");
      assert (LEN_W < PC_W) else $error("length field too wide");
      assert (LEN_W >= 3) else $error("length field cannot hold 6");
      assert (CYC_W >= 3) else $error("cycle field cannot hold 6");
   end

   dec_t             dec;
   logic             cond;
   logic [DW-1:0]    set_data;
   logic [PC_W-1:0]  seq_pc;
   logic [PC_W-1:0]  jump_pc;
   logic [CYC_W-1:0] cyc;
   logic             fire;
   logic             is_bset;
   logic             take_now;

   btb_decode u_decode (
      .opcode (in_opcode),
      .dec    (dec)
   );

   btb_bit_eval #(.DW(DW)) u_eval (
      .kind    (dec.kind),
      .operand (in_operand),
      .mask    (in_mask),
      .cond    (cond),
      .wdata   (set_data)
   );

   btb_target #(.PC_W(PC_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_target (
      .pc      (in_pc),
      .len     (in_len),
      .disp    (in_disp),
      .seq_pc  (seq_pc),
      .jump_pc (jump_pc)
   );

   btb_cycles #(.LEN_W(LEN_W), .CYC_W(CYC_W)) u_cycles (
      .dec    (dec),
      .len    (in_len),
      .cycles (cyc)
   );

   assign fire     = in_valid && (dec.kind != K_NONE);
   assign is_bset  = (dec.kind == K_BSET);
   assign take_now = !is_bset && cond;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_taken   <= 1'b0;
         out_next_pc <= '0;
         out_wr_data <= '0;
         out_wr_en   <= 1'b0;
         out_cycles  <= '0;
      end else begin
         out_valid <= fire;
         out_wr_en <= fire && is_bset;
         if (fire) begin
            out_taken   <= take_now;
            out_next_pc <= take_now ? jump_pc : seq_pc;
            out_wr_data <= is_bset ? set_data : '0;
            out_cycles  <= cyc;
         end
      end
   end

   // R9: no accepted input, no result
   a_r9_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !out_wr_en);

   // R5, R6: the write strobe only with a valid, untaken result
   a_r5_wr_with_result: assert property (@(posedge clk) disable iff (!rst_n)
      out_wr_en |-> out_valid && !out_taken);

   // R2: direct branch-on-clear decision
   a_r2_clear_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_opcode == 8'h4F) |=>
         out_taken == (($past(in_operand) & $past(in_mask)) == '0));

   // R3: direct branch-on-set decision
   a_r3_set_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_opcode == 8'h4E) |=>
         out_taken == ((~$past(in_operand) & $past(in_mask)) == '0));

   // R4: fall-through address
   a_r4_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!out_valid || out_taken ||
         out_next_pc == $past(in_pc) + PC_W'($past(in_len))));

   // R7, R8: cycle cost stays within 4..6
   a_r7_cycle_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_cycles >= CYC_W'(4) && out_cycles <= CYC_W'(6)));

   // R10: results hold while no new one arrives
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid && $past(rst_n) |-> $stable(out_next_pc) && $stable(out_cycles));

endmodule

// File: tb/test_btb_unit.sv
module test_btb_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_opcode = 8'h00;
   logic [7:0]  in_operand = 8'h00;
   logic [7:0]  in_mask = 8'h00;
   logic [7:0]  in_disp = 8'h00;
   logic [15:0] in_pc = 16'h0000;
   logic [2:0]  in_len = 3'd0;
   logic        out_valid;
   logic        out_taken;
   logic [15:0] out_next_pc;
   logic [7:0]  out_wr_data;
   logic        out_wr_en;
   logic [2:0]  out_cycles;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   btb_unit i_btb_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
      .in_operand(in_operand), .in_mask(in_mask), .in_disp(in_disp),
      .in_pc(in_pc), .in_len(in_len), .out_valid(out_valid),
      .out_taken(out_taken), .out_next_pc(out_next_pc),
      .out_wr_data(out_wr_data), .out_wr_en(out_wr_en), .out_cycles(out_cycles)
   );

   // reference model state
   logic        m_valid = 0, m_taken = 0, m_wen = 0;
   logic [15:0] m_pc = 0;
   logic [7:0]  m_wdata = 0;
   logic [2:0]  m_cyc = 0;
   string       m_tag = "R1";

   // 0 none, 1 clear-branch, 2 set-branch, 3 bit-set
   function automatic int kind_of(input logic [7:0] op);
      case (op)
         8'h4F, 8'h1F, 8'h0F: return 1;
         8'h4E, 8'h1E, 8'h0E: return 2;
         8'h4C, 8'h1C, 8'h0C: return 3;
         default:             return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int k;
      int c;
      logic t;
      logic [15:0] seq;
      k = kind_of(in_opcode);
      if (!rst_n) begin
         m_valid <= 0; m_taken <= 0; m_wen <= 0; m_pc <= 0; m_wdata <= 0; m_cyc <= 0;
         m_tag <= "R1";
      end else if (in_valid && k != 0) begin
         seq = in_pc + 16'(in_len);
         if (k == 1) t = ((in_operand & in_mask) == 8'h00);
         else if (k == 2) t = ((~in_operand & in_mask) == 8'h00);
         else t = 0;
         if (k == 3) c = (in_opcode == 8'h0C && in_len >= 6) ? 6 : 4;
         else if (in_opcode[7:4] == 4'h4) c = 4;
         else if (in_opcode[7:4] == 4'h1) c = 5;
         else c = (in_len <= 4) ? 4 : (in_len >= 6) ? 6 : 5;
         m_valid <= 1;
         m_taken <= t;
         m_pc    <= t ? seq + {{8{in_disp[7]}}, in_disp} : seq;
         m_wen   <= (k == 3);
         m_wdata <= (k == 3) ? (in_operand | in_mask) : 8'h00;
         m_cyc   <= 3'(c);
         m_tag   <= (k == 1) ? "R2" : (k == 2) ? "R3" : "R5";
      end else begin
         m_valid <= 0;
         m_wen   <= 0;
         m_tag   <= (in_valid && rst_n) ? "R10" : "R9";
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // compare on every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk(m_tag, "valid", int'(out_valid), int'(m_valid));
         chk(m_tag, "taken", int'(out_taken), int'(m_taken));
         chk("R4", "next_pc", int'(out_next_pc), int'(m_pc));
         chk((m_tag == "R5") ? "R5" : "R6", "wr_en", int'(out_wr_en), int'(m_wen));
         chk((m_tag == "R5") ? "R5" : "R6", "wr_data", int'(out_wr_data), int'(m_wdata));
         chk((m_tag == "R5") ? "R8" : "R7", "cycles", int'(out_cycles), int'(m_cyc));
      end
   end

   task automatic op(input logic [7:0] opc, input logic [7:0] opr, input logic [7:0] msk,
                     input logic [7:0] d, input logic [15:0] pc, input logic [2:0] len);
      @(negedge clk);
      in_valid = 1; in_opcode = opc; in_operand = opr; in_mask = msk;
      in_disp = d; in_pc = pc; in_len = len;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 0;
      in_opcode = 8'hA5; in_operand = 8'h3C; in_pc = 16'h1357; in_len = 3'd7;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs zero under reset
      chk("R1", "reset valid", int'(out_valid), 0);
      chk("R1", "reset pc", int'(out_next_pc), 0);
      chk("R1", "reset cycles", int'(out_cycles), 0);
      rst_n = 1;
      // R2 clear-branch: taken and not taken in each mode
      op(8'h4F, 8'hF0, 8'h0F, 8'h10, 16'h1000, 3'd4);
      op(8'h4F, 8'hF1, 8'h0F, 8'h10, 16'h1000, 3'd4);
      op(8'h1F, 8'h00, 8'hFF, 8'h80, 16'h0002, 3'd5);  // R4 backward wrap
      op(8'h0F, 8'hFF, 8'h00, 8'h7F, 16'hFFF0, 3'd6);  // R4 forward wrap, R7 len 6
      op(8'h0F, 8'h01, 8'h01, 8'h7F, 16'h2000, 3'd4);
      op(8'h0F, 8'h55, 8'hAA, 8'hFE, 16'h2000, 3'd5);
      // R3 set-branch
      op(8'h4E, 8'hFF, 8'hFF, 8'h04, 16'h3000, 3'd4);
      op(8'h1E, 8'hFE, 8'hFF, 8'h04, 16'h3000, 3'd5);
      op(8'h0E, 8'h80, 8'h80, 8'hF0, 16'h3000, 3'd6);
      op(8'h0E, 8'h00, 8'h00, 8'hF0, 16'h3000, 3'd3);  // R7 clamp low
      op(8'h0F, 8'h00, 8'h01, 8'h00, 16'h3000, 3'd7);  // R7 clamp high
      // R5, R8 bit-set, back-to-back then idle
      op(8'h4C, 8'h12, 8'h81, 8'h40, 16'h4000, 3'd4);
      op(8'h1C, 8'h00, 8'h00, 8'h40, 16'h4000, 3'd5);
      op(8'h0C, 8'h0F, 8'hF0, 8'h40, 16'h4000, 3'd6);
      op(8'h0C, 8'h0F, 8'h10, 8'h40, 16'h4000, 3'd5);
      idle();
      idle();
      // R10 unrecognised opcodes
      op(8'h4D, 8'h00, 8'hFF, 8'h20, 16'h5000, 3'd4);
      op(8'h2F, 8'h00, 8'hFF, 8'h20, 16'h5000, 3'd4);
      op(8'h0A, 8'h00, 8'hFF, 8'h20, 16'h5000, 3'd4);
      op(8'h4F, 8'h00, 8'hFF, 8'h20, 16'h5000, 3'd4);
      // random mix
      for (int i = 0; i < 2000; i++) begin
         logic [7:0] opc;
         logic [2:0] ln;
         int sel;
         sel = $urandom_range(0, 11);
         case (sel)
            0: opc = 8'h4F; 1: opc = 8'h1F; 2: opc = 8'h0F;
            3: opc = 8'h4E; 4: opc = 8'h1E; 5: opc = 8'h0E;
            6: opc = 8'h4C; 7: opc = 8'h1C; 8: opc = 8'h0C;
            9: opc = 8'($urandom);
            default: opc = 8'h00;
         endcase
         ln = (opc[7:4] == 4'h4) ? 3'd4 : (opc[7:4] == 4'h1) ? 3'd5 : 3'($urandom_range(4, 6));
         if (sel == 10) idle();
         else op(opc, 8'($urandom), ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom),
                 8'($urandom), 16'($urandom), ln);
      end
      idle();
      idle();
      // R1: synchronous reset clears a held result
      rst_n = 0;
      @(negedge clk);
      chk("R1", "reset clears taken", int'(out_taken), 0);
      chk("R1", "reset clears wr_data", int'(out_wr_data), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule